// File: doc/BRIEF.md
# Digitally Trimmed Real-Time-Clock Prescaler

This block divides a nominal 32,768 Hz oscillator clock down to a one-second tick and a one-minute tick. It adjusts the clock rate digitally and leaves the crystal alone. A first stage divides by 128. A second stage counts those periods, 256 per nominal second. Within a repeating cycle of 64 minutes, the first second of an eligible minute has its terminal count moved. The move is one prescale period later, which slows the clock. Or it is two prescale periods earlier, which speeds the clock up.

A 6-bit calibration word sets the size and direction of the trim. Bit 5 selects the direction (1 = speed up, 0 = slow down). Bits 4..0 hold the magnitude N, from 0 to 31. The word is captured once per minute. A stop input freezes the whole chain. A test-enable input brings out a 512 Hz square wave, taken from the first stage. The square wave is never trimmed, so production test can measure the raw oscillator error from it.

All counts are parameters. The defaults are a 7-bit first stage, 256 prescale periods per second and 60 seconds per minute.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: While reset is asserted, `sec_tick_o`, `min_tick_o` and `ft_o` are all low.
- R2: An uncorrected second lasts exactly 2^PRE_W × SEC_DIV running clock cycles (32,768 by default).
- R3: `min_tick_o` pulses only together with `sec_tick_o`, on every SEC_PER_MIN-th second tick.
- R4: With bit 5 = 0 and magnitude N > 0, second 0 of each minute with index below 2N (of the 64-minute cycle) lasts one prescale period (128 cycles) longer.
- R5: With bit 5 = 1 and magnitude N > 0, second 0 of each minute with index below 2N lasts two prescale periods (256 cycles) shorter.
- R6: With magnitude 0, every second has nominal length, whatever bit 5 holds.
- R7: Minutes 62 and 63 of the cycle are never corrected. Over any 64 consecutive minutes, the running cycles total 64 × SEC_PER_MIN × nominal second, minus 512·N for speed-up or plus 256·N for slow-down (default sizes).
- R8: The calibration word is captured when a minute ends. A change made during a minute has no effect until the next minute starts, and a second in progress keeps the length it started with.
- R9: While `stop_i` is high, the counters hold, no tick is produced and `ft_o` is low. After release, the interrupted second continues where it left off.
- R10: When `ft_en_i` = 1 and `stop_i` = 0, `ft_o` toggles every 32 cycles (512 Hz at the default sizes), whatever the calibration word. Otherwise `ft_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc_i | input | 1 | Oscillator-domain clock |
| rst_osc_ni | input | 1 | Asynchronous active-low reset |
| cal_i | input | 6 | Calibration word: bit 5 = speed-up, bits 4..0 = magnitude |
| stop_i | input | 1 | Freezes the divider chain when high |
| ft_en_i | input | 1 | Enables the frequency-test square wave |
| sec_tick_o | output | 1 | One-cycle pulse when a second ends |
| min_tick_o | output | 1 | One-cycle pulse when a minute ends |
| ft_o | output | 1 | 512 Hz test square wave, or low |

## Verification
The bench runs the block with reduced sizes: a 64-cycle prescale period, 4 periods per second and 2 seconds per minute. A model of minute and second position predicts the running length of every second. Full 64-minute windows are then summed for several calibration words:
- Slow-down by 31 separates the long-second path and the 62-minute limit.
- Speed-up by 31 exercises the short path.
- Magnitude 0 with bit 5 set shows that the sign alone does nothing.
- A seeded random word catches wrong scaling of the eligible-minute window.

In directed cases, the calibration word is changed in the middle of a corrected second. The chain is frozen in mid-second. The test wave's period is measured while a large trim is pending.

// File: rtl/rtrim_pkg.sv
package rtrim_pkg;

  // Length variant of the second in progress
  typedef enum logic [1:0] {
    TRIM_NONE  = 2'd0,
    TRIM_LONG  = 2'd1,
    TRIM_SHORT = 2'd2
  } trim_e;

  typedef struct packed {
    logic       speed_up;
    logic [4:0] mag;
  } cal_t;

  localparam int unsigned CYC_MINUTES = 64;
  localparam int unsigned LAST_TRIM_MINUTES = 62;

endpackage

// File: rtl/rtrim_pre.sv
// First divider stage; also the source of the frequency-test phase
module rtrim_pre #(
  parameter int unsigned PRE_W = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic wrap_o,
  output logic ft_phase_o
);
  // bit 5 toggles every 32 cycles: 512 Hz from 32,768 Hz; needs PRE_W >= 6
  localparam int unsigned FT_BIT = 5;

  logic [PRE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (run_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign wrap_o     = run_i && (cnt_q == {PRE_W{1'b1}});
  assign ft_phase_o = cnt_q[FT_BIT];

  assert_stop_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));

  assert_ft_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ft_phase_o) |-> $past(run_i));

endmodule

// File: rtl/rtrim_sec.sv
// Second stage: counts prescale periods; terminal count depends on trim mode
module rtrim_sec
  import rtrim_pkg::*;
#(
  parameter int unsigned SEC_DIV = 256
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  step_i,
  input  trim_e mode_i,
  output logic  done_o
);
  localparam int unsigned CNT_W = $clog2(SEC_DIV + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, last;

  always_comb begin
    unique case (mode_i)
      TRIM_LONG:  last = CNT_W'(SEC_DIV);
      TRIM_SHORT: last = CNT_W'(SEC_DIV - 3);
      default:    last = CNT_W'(SEC_DIV - 1);
    endcase
  end

  assign done_o = step_i && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (done_o)      cnt_d = '0;
    else if (step_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(SEC_DIV));

  assert_mode_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (mode_i == $past(mode_i)));

endmodule

// File: rtl/rtrim_seq.sv
// Seconds-in-minute and minute-in-cycle position, calibration capture
module rtrim_seq
  import rtrim_pkg::*;
#(
  parameter int unsigned SEC_PER_MIN = 60
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sec_done_i,
  input  logic [5:0] cal_i,
  output trim_e      mode_o,
  output logic       min_done_o
);
  localparam int unsigned SIDX_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam int unsigned MIN_W  = $clog2(CYC_MINUTES);

  logic [SIDX_W-1:0] sec_q, sec_d;
  logic [MIN_W-1:0]  min_q, min_d;
  cal_t              cal_q, cal_d;
  logic              elig;

  assign min_done_o = sec_done_i && (sec_q == SIDX_W'(SEC_PER_MIN - 1));

  always_comb begin
    sec_d = sec_q;
    min_d = min_q;
    cal_d = cal_q;
    if (min_done_o) begin
      sec_d = '0;
      min_d = min_q + 1'b1;
      cal_d = cal_t'(cal_i);
    end else if (sec_done_i) begin
      sec_d = sec_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      min_q <= '0;
      cal_q <= '0;
    end else begin
      sec_q <= sec_d;
      min_q <= min_d;
      cal_q <= cal_d;
    end
  end

  // first second of a minute whose index is below twice the magnitude
  assign elig   = (sec_q == '0) && (min_q < MIN_W'({cal_q.mag, 1'b0}));
  assign mode_o = !elig ? TRIM_NONE : (cal_q.speed_up ? TRIM_SHORT : TRIM_LONG);

  assert_cal_latch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cal_q) |-> $past(min_done_o));

  assert_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != TRIM_NONE) |-> (min_q < MIN_W'(LAST_TRIM_MINUTES)));

  assert_zero_mag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_q.mag == '0) |-> (mode_o == TRIM_NONE));

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
  import rtrim_pkg::*;
#(
  parameter int unsigned PRE_W       = 7,
  parameter int unsigned SEC_DIV     = 256,
  parameter int unsigned SEC_PER_MIN = 60
) (
  input  logic       clk_osc_i,
  input  logic       rst_osc_ni,
  input  logic [5:0] cal_i,
  input  logic       stop_i,
  input  logic       ft_en_i,
  output logic       sec_tick_o,
  output logic       min_tick_o,
  output logic       ft_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       run, pre_wrap, ft_phase, sec_done, min_done;
  trim_e      mode;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_osc_i or negedge rst_osc_ni) begin
    if (!rst_osc_ni) rst_sync_q <= 2'b00;
    else             rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign run = ~stop_i;

  rtrim_pre #(.PRE_W(PRE_W)) u_pre (
    .clk_i      (clk_osc_i),
    .rst_ni     (rst_n),
    .run_i      (run),
    .wrap_o     (pre_wrap),
    .ft_phase_o (ft_phase)
  );

  rtrim_sec #(.SEC_DIV(SEC_DIV)) u_sec (
    .clk_i  (clk_osc_i),
    .rst_ni (rst_n),
    .step_i (pre_wrap),
    .mode_i (mode),
    .done_o (sec_done)
  );

  rtrim_seq #(.SEC_PER_MIN(SEC_PER_MIN)) u_seq (
    .clk_i      (clk_osc_i),
    .rst_ni     (rst_n),
    .sec_done_i (sec_done),
    .cal_i      (cal_i),
    .mode_o     (mode),
    .min_done_o (min_done)
  );

  assign sec_tick_o = sec_done;
  assign min_tick_o = min_done;
  assign ft_o       = ft_en_i & run & ft_phase;

  assert_min_on_sec_R3: assert property (@(posedge clk_osc_i) disable iff (!rst_n)
    min_tick_o |-> sec_tick_o);

  assert_quiet_stop_R9: assert property (@(posedge clk_osc_i) disable iff (!rst_n)
    stop_i |-> !sec_tick_o);

endmodule

// File: tb/rtc_trim_prescaler_bench.sv
module rtc_trim_prescaler_bench;
  localparam int PW    = 6;
  localparam int SD    = 4;
  localparam int SPM   = 2;
  localparam int PER   = 1 << PW;
  localparam int BASE  = PER * SD;
  localparam longint CYCT = 64 * SPM * BASE;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cal = 6'd0;
  logic       stop = 1'b0;
  logic       ften = 1'b0;
  logic       sec_tick, min_tick, ft;

  int errors = 0, checks = 0;
  int sec_ticks = 0, min_ticks = 0;
  int run_cnt = 0, wall_cnt = 0, last_run = 0, last_wall = 0;
  longint tot_run = 0, tot_at_min = 0;
  int b_min = 0, b_sec = 0;
  logic [5:0] b_cal = 6'd0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_trim_prescaler #(.PRE_W(PW), .SEC_DIV(SD), .SEC_PER_MIN(SPM)) u_rtc_trim_prescaler (
    .clk_osc_i  (clk),
    .rst_osc_ni (rst_n),
    .cal_i      (cal),
    .stop_i     (stop),
    .ft_en_i    (ften),
    .sec_tick_o (sec_tick),
    .min_tick_o (min_tick),
    .ft_o       (ft)
  );

  task automatic chk(input bit ok, input string tag, input longint act,
                     input longint exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_len(input int mn, input int sc, input logic [5:0] c);
    int n = int'(c[4:0]);
    if (sc == 0 && mn < 2 * n) return c[5] ? BASE - 2 * PER : BASE + PER;
    return BASE;
  endfunction

  function automatic longint exp_total(input logic [5:0] c);
    longint n = longint'(c[4:0]);
    return c[5] ? CYCT - 4 * PER * n : CYCT + 2 * PER * n;
  endfunction

  function automatic string tag_for(input int mn, input int sc, input logic [5:0] c);
    if (exp_len(mn, sc, c) != BASE) return c[5] ? "R5" : "R4";
    if (c[4:0] == 5'd0) return "R6";
    if (mn >= 62) return "R7";
    return "R2";
  endfunction

  // monitor: running cycles per second against a model of the position
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e;
      wall_cnt++;
      if (!stop) begin
        run_cnt++;
        tot_run++;
      end
      if (min_tick && !sec_tick) chk(1'b0, "R3", 1, 0, "minute tick without second tick");
      if (sec_tick) begin
        e = exp_len(b_min, b_sec, b_cal);
        if (sec_ticks > 0)
          chk(run_cnt == e, tag_for(b_min, b_sec, b_cal), run_cnt, e, "second length");
        chk(min_tick == (b_sec == SPM - 1), "R3", min_tick, (b_sec == SPM - 1), "minute tick placement");
        last_run  = run_cnt;
        last_wall = wall_cnt;
        run_cnt   = 0;
        wall_cnt  = 0;
        if (b_sec == SPM - 1) begin
          b_sec = 0;
          b_min = (b_min + 1) % 64;
          b_cal = cal;
        end else begin
          b_sec++;
        end
        if (min_tick) begin
          min_ticks++;
          tot_at_min = tot_run;
        end
        sec_ticks++;
      end
    end
  end

  task automatic measure(input logic [5:0] c);
    int k, s, m_now;
    logic [5:0] old;
    longint t0, tot;
    k = min_ticks;
    wait (min_ticks == k + 1);
    m_now = b_min;
    old   = b_cal;
    @(posedge clk); #1 cal = c;   // mid second 0 of a minute
    s = sec_ticks;
    wait (sec_ticks == s + 1);
    chk(last_run == exp_len(m_now, 0, old), "R8", last_run, exp_len(m_now, 0, old),
        "second in progress kept its length");
    wait (min_ticks == k + 2);
    t0 = tot_at_min;
    wait (min_ticks == k + 66);
    tot = tot_at_min - t0;
    chk(tot == exp_total(c), "R7", tot, exp_total(c), $sformatf("64-minute total cal=%02h", c));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int s, prev_i;
    logic prev;
    logic [5:0] rc;
    void'($urandom(32'd2024));

    // R1: reset state
    ften = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(!sec_tick && !min_tick && !ft, "R1", {sec_tick, min_tick, ft}, 0, "outputs in reset");
    end
    @(posedge clk); #1 rst_n = 1'b1; ften = 1'b0;

    wait (sec_ticks == 2);

    // R9: stop in mid-second
    repeat (50) @(posedge clk);
    #1 stop = 1'b1; ften = 1'b1;
    repeat (100) begin
      @(negedge clk);
      chk(!sec_tick && !min_tick, "R9", {sec_tick, min_tick}, 0, "ticks while stopped");
      chk(!ft, "R10", ft, 0, "test wave while stopped");
    end
    @(posedge clk); #1 stop = 1'b0; ften = 1'b0;
    s = sec_ticks;
    wait (sec_ticks == s + 1);
    chk(last_wall == BASE + 100, "R9", last_wall, BASE + 100, "stopped second resumed");

    // R10: test wave period with a large trim pending
    @(posedge clk); #1 ften = 1'b1; cal = 6'h3F;
    prev = ft;
    prev_i = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (ft !== prev) begin
        if (prev_i >= 0) chk(i - prev_i == 32, "R10", i - prev_i, 32, "half period");
        prev_i = i;
        prev = ft;
      end
    end
    @(posedge clk); #1 ften = 1'b0; cal = 6'h00;
    repeat (40) begin
      @(negedge clk);
      chk(!ft, "R10", ft, 0, "test wave disabled");
    end

    // full-cycle totals
    measure(6'h1F);
    measure(6'h3F);
    measure(6'h20);
    rc = {1'($urandom % 2), 5'(1 + $urandom % 30)};
    measure(rc);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule